// File: doc/BRIEF.md
# Framed Serial Link Transmitter

This block takes a parallel payload and sends it as a framed serial bit stream together with a forwarded clock. One data bit goes out with every edge of the forwarded clock, both rising and falling. The forwarded clock is produced from an internal bit-rate clock: each bit period toggles the forwarded clock once and presents a new data bit.

A host sets up a 4-bit frame type, an 8-bit user field, a payload and a 4-bit tag, and then pulses `start`. The payload is either one 16-bit word or eight 16-bit words, picked by `long_sel`. The transmitter does the following, in order:

- four clock-only edges;
- a start delimiter;
- the frame type, the user field and the payload;
- an 8-bit CRC;
- the tag;
- an end delimiter;
- four more clock-only edges.

Every field goes out most significant bit first. When the frame is complete, the block returns to idle and pulses `done`. It captures all inputs when it accepts `start`, so the host may prepare the next frame while the current one is on the wire.

Top module: `frame_link_tx`

## Requirements
- R1: While idle (after reset and between frames), `tx_clk` is 0, `tx_dat` is 0 and `busy` is 0.
- R2: `start` sampled high while idle raises `busy` in the next cycle. From then on, `tx_clk` toggles once per cycle while busy, each toggle carries one bit on `tx_dat`, and the frame ends with `tx_clk` low.
- R3: The first four edges of a frame and the last four edges carry data 0, with no frame content.
- R4: The start delimiter is the 4-bit pattern 1001 and the end delimiter is 0110, each sent as written, leftmost bit first.
- R5: After the start delimiter the wire order is: frame type (4 bits), user field (8 bits), payload, CRC (8 bits), tag (4 bits), end delimiter. Every field is sent MSB first.
- R6: With `long_sel`=0 the payload is `payload[15:0]` (bit 15 first) and the frame is 56 edges long. With `long_sel`=1 the payload is `payload[127:0]` (bit 127 first) and the frame is 168 edges long.
- R7: The CRC is CRC-8 with polynomial x^8+x^2+x+1 (0x07) and initial value 0x00. It is fed one bit at a time with the frame type, user field and payload bits in wire order, and it is sent MSB first.
- R8: `start` has no effect while `busy` is 1. The current frame runs to completion unchanged, and no new frame begins after it.
- R9: Frame type, user field, payload, tag and `long_sel` are captured when `start` is accepted. Changing them during a frame does not alter that frame.
- R10: `done` is high for exactly one cycle: the cycle after the final trailing edge. `busy` is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to send a frame; accepted only when idle |
| frm_type | input | 4 | Frame type field |
| user_data | input | 8 | User-defined field |
| long_sel | input | 1 | 0: one 16-bit word, 1: eight 16-bit words |
| payload | input | 128 | Payload; the short frame uses bits 15:0 |
| tag | input | 4 | Frame tag field |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the frame ends |
| tx_clk | output | 1 | Forwarded clock |
| tx_dat | output | 1 | Serial data, one bit per forwarded-clock edge |

## Verification
A phase counter that ends a phase early or late changes the number of forwarded-clock edges. It also shifts every later field, so the delimiter or CRC comparison on the captured bit list fails within that same frame. A CRC register that updates on the wrong bits shows up at the ports only during the eight CRC edges. A latching error shows up only when the inputs change during a frame. The bench therefore:

- rebuilds each frame bit by bit on its own;
- compares every field span separately;
- perturbs `start` and all data inputs in the middle of frames.

// File: rtl/flt_pkg.sv
// Shared types and constants for the framed serial link transmitter.
// Assumes a single bit-rate clock domain.
package flt_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_HEAD,
        PH_CRC,
        PH_TAIL,
        PH_POST
    } phase_t;

    localparam int DELIM_W = 4;
    localparam logic [DELIM_W-1:0] SOF_PAT = 4'b1001;
    localparam logic [DELIM_W-1:0] EOF_PAT = 4'b0110;
endpackage

// File: rtl/flt_shreg.sv
// Parallel-load, left-shifting register that presents its MSB.
// Assumes load and shift are never both high (load takes priority).
module flt_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr_q;

    // Capture on load, shift one place toward the MSB on shift.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr_q <= '0;
        else if (load)  sr_q <= load_val;
        else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
    end

    assign msb = sr_q[W-1];
endmodule

// File: rtl/flt_crc8.sv
// Serial CRC generator. It folds in one bit per cycle on upd, then on shift
// it drains the remainder MSB first.
// Assumes that clr, upd and shift are mutually exclusive.
module flt_crc8 #(
    parameter int           W    = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic upd,
    input  logic din,
    input  logic shift,
    output logic msb
);
    logic [W-1:0] crc_q;
    logic         fb;

    assign fb = crc_q[W-1] ^ din;

    // Clear, accumulate one bit, or drain the remainder.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc_q <= '0;
        else if (upd)      crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        else if (shift)    crc_q <= {crc_q[W-2:0], 1'b0};
    end

    assign msb = crc_q[W-1];

    // R7: while draining, the remainder moves toward the MSB unchanged
    assert_crc_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clr && !upd) |=> (crc_q[W-1] == $past(crc_q[W-2])));
endmodule

// File: rtl/flt_seq.sv
// Frame sequencer: walks the phases pad, head, CRC, tail, pad and counts the
// bits in each phase. It issues the per-cycle controls and the done pulse.
// Assumes that start is only acted on in the idle phase.
module flt_seq
    import flt_pkg::*;
#(
    parameter int EDGE_PAD   = 4,
    parameter int SOF_W      = 4,
    parameter int SHORT_HEAD = 32,
    parameter int LONG_HEAD  = 144,
    parameter int CRC_W      = 8,
    parameter int TAIL_W     = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   long_sel,
    output phase_t phase,
    output logic   load,
    output logic   head_shift,
    output logic   crc_upd,
    output logic   crc_shift,
    output logic   tail_shift,
    output logic   done
);
    localparam int CNT_W = $clog2(LONG_HEAD + 1);

    phase_t           phase_q, phase_nx;
    logic [CNT_W-1:0] cnt_q, last_cnt;
    logic             long_q, done_q;

    // Final count of the current phase and the phase that follows it.
    always_comb begin
        last_cnt = '0;
        phase_nx = PH_IDLE;
        case (phase_q)
            PH_PRE:  begin last_cnt = CNT_W'(EDGE_PAD - 1); phase_nx = PH_HEAD; end
            PH_HEAD: begin
                last_cnt = long_q ? CNT_W'(LONG_HEAD - 1) : CNT_W'(SHORT_HEAD - 1);
                phase_nx = PH_CRC;
            end
            PH_CRC:  begin last_cnt = CNT_W'(CRC_W - 1);    phase_nx = PH_TAIL; end
            PH_TAIL: begin last_cnt = CNT_W'(TAIL_W - 1);   phase_nx = PH_POST; end
            PH_POST: begin last_cnt = CNT_W'(EDGE_PAD - 1); phase_nx = PH_IDLE; end
            default: begin last_cnt = '0;                   phase_nx = PH_IDLE; end
        endcase
    end

    // Phase/count state, length capture and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            long_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase_q == PH_IDLE) begin
                if (start) begin
                    phase_q <= PH_PRE;
                    cnt_q   <= '0;
                    long_q  <= long_sel;
                end
            end else if (cnt_q == last_cnt) begin
                cnt_q   <= '0;
                phase_q <= phase_nx;
                done_q  <= (phase_q == PH_POST);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase      = phase_q;
    assign load       = (phase_q == PH_IDLE) && start;
    assign head_shift = (phase_q == PH_HEAD);
    assign crc_upd    = head_shift && (cnt_q >= CNT_W'(SOF_W));
    assign crc_shift  = (phase_q == PH_CRC);
    assign tail_shift = (phase_q == PH_TAIL);
    assign done       = done_q;

    // R10: done lasts a single cycle
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: the last trailing edge is followed by done and idle
    assert_done_after_post_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_POST && cnt_q == last_cnt) |=> (done && phase_q == PH_IDLE));
    // R5: only one field source drives the wire at a time
    assert_one_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({head_shift, crc_shift, tail_shift}));
    // R8: start in the middle of a frame does not restart it
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && phase_q inside {PH_HEAD, PH_CRC, PH_TAIL, PH_POST}) |=> (phase_q != PH_PRE));
endmodule

// File: rtl/frame_link_tx.sv
// Framed serial link transmitter top. It captures a frame on start and sends
// it on tx_dat, one bit per toggle of the forwarded clock tx_clk.
// Assumes clk runs at the bit rate. tx_clk therefore runs at half of it.
module frame_link_tx
    import flt_pkg::*;
#(
    parameter int           WORD_W     = 16,
    parameter int           LONG_WORDS = 8,
    parameter int           TYPE_W     = 4,
    parameter int           USER_W     = 8,
    parameter int           TAG_W      = 4,
    parameter int           EDGE_PAD   = 4,
    parameter int           CRC_W      = 8,
    parameter logic [7:0]   CRC_POLY   = 8'h07
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [TYPE_W-1:0]            frm_type,
    input  logic [USER_W-1:0]            user_data,
    input  logic                         long_sel,
    input  logic [WORD_W*LONG_WORDS-1:0] payload,
    input  logic [TAG_W-1:0]             tag,
    output logic                         busy,
    output logic                         done,
    output logic                         tx_clk,
    output logic                         tx_dat
);
    localparam int LONG_BITS  = WORD_W * LONG_WORDS;
    localparam int PRE_BITS   = DELIM_W + TYPE_W + USER_W;
    localparam int LONG_HEAD  = PRE_BITS + LONG_BITS;
    localparam int SHORT_HEAD = PRE_BITS + WORD_W;
    localparam int TAIL_W     = TAG_W + DELIM_W;

    phase_t                 phase;
    logic                   load, head_shift, crc_upd, crc_shift, tail_shift;
    logic                   head_msb, crc_msb, tail_msb, bit_now;
    logic [LONG_HEAD-1:0]   head_val;
    logic [PRE_BITS-1:0]    pre_val;

    assign pre_val = {SOF_PAT, frm_type, user_data};

    // The short payload is left-aligned so that the head always drains from its MSB.
    generate
        if (LONG_BITS > WORD_W) begin : g_pad
            assign head_val = long_sel ? {pre_val, payload}
                : {pre_val, payload[WORD_W-1:0], {(LONG_BITS-WORD_W){1'b0}}};
        end else begin : g_nopad
            assign head_val = {pre_val, payload};
        end
    endgenerate

    flt_seq #(
        .EDGE_PAD(EDGE_PAD), .SOF_W(DELIM_W), .SHORT_HEAD(SHORT_HEAD),
        .LONG_HEAD(LONG_HEAD), .CRC_W(CRC_W), .TAIL_W(TAIL_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .long_sel(long_sel),
        .phase(phase), .load(load), .head_shift(head_shift), .crc_upd(crc_upd),
        .crc_shift(crc_shift), .tail_shift(tail_shift), .done(done)
    );

    flt_shreg #(.W(LONG_HEAD)) u_head (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(head_val),
        .shift(head_shift), .msb(head_msb)
    );

    flt_shreg #(.W(TAIL_W)) u_tail (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val({tag, EOF_PAT}),
        .shift(tail_shift), .msb(tail_msb)
    );

    flt_crc8 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(load), .upd(crc_upd), .din(head_msb),
        .shift(crc_shift), .msb(crc_msb)
    );

    // Pick the bit that belongs to the current phase; padding phases send 0.
    always_comb begin
        case (phase)
            PH_HEAD: bit_now = head_msb;
            PH_CRC:  bit_now = crc_msb;
            PH_TAIL: bit_now = tail_msb;
            default: bit_now = 1'b0;
        endcase
    end

    assign busy = (phase != PH_IDLE);

    // Toggle the forwarded clock and register one data bit per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_clk <= 1'b0;
            tx_dat <= 1'b0;
        end else begin
            tx_clk <= busy ? ~tx_clk : 1'b0;
            tx_dat <= busy ? bit_now : 1'b0;
        end
    end

    // R1: quiet wire while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tx_clk && !tx_dat));
    // R2: every busy cycle produces one forwarded-clock edge
    assert_edge_per_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (tx_clk != $past(tx_clk)));
    // R3: padding edges carry no data
    assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PRE || phase == PH_POST) |=> !tx_dat);
endmodule

// File: tb/test_frame_link_tx.sv
module test_frame_link_tx;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [3:0]   frm_type = '0;
    logic [7:0]   user_data = '0;
    logic         long_sel = 1'b0;
    logic [127:0] payload = '0;
    logic [3:0]   tag = '0;
    logic         busy, done, tx_clk, tx_dat;

    int n_checks = 0;
    int n_fail   = 0;

    logic exp_bits [0:255];
    logic got_bits [0:255];
    int   exp_len;
    int   got_len;
    logic [7:0] bench_crc;

    frame_link_tx i_frame_link_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .frm_type(frm_type),
        .user_data(user_data), .long_sel(long_sel), .payload(payload), .tag(tag),
        .busy(busy), .done(done), .tx_clk(tx_clk), .tx_dat(tx_dat)
    );

    always #10 clk = ~clk;

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected finished)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_bit(input logic b, input bit in_crc);
        logic fb;
        exp_bits[exp_len] = b;
        exp_len++;
        if (in_crc) begin
            fb = bench_crc[7] ^ b;
            bench_crc = {bench_crc[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
    endtask

    task automatic build(input logic [3:0] ty, input logic [7:0] ud, input logic lg,
                         input logic [127:0] pl, input logic [3:0] tg);
        logic [7:0] crc_snap;
        exp_len = 0;
        bench_crc = 8'h00;
        for (int i = 0; i < 4; i++) push_bit(1'b0, 1'b0);
        for (int i = 3; i >= 0; i--) push_bit(4'b1001 >> i, 1'b0);
        for (int i = 3; i >= 0; i--) push_bit(ty[i], 1'b1);
        for (int i = 7; i >= 0; i--) push_bit(ud[i], 1'b1);
        for (int i = (lg ? 127 : 15); i >= 0; i--) push_bit(pl[i], 1'b1);
        crc_snap = bench_crc;
        for (int i = 7; i >= 0; i--) push_bit(crc_snap[i], 1'b0);
        for (int i = 3; i >= 0; i--) push_bit(tg[i], 1'b0);
        for (int i = 3; i >= 0; i--) push_bit(4'b0110 >> i, 1'b0);
        for (int i = 0; i < 4; i++) push_bit(1'b0, 1'b0);
    endtask

    task automatic check_span(input int lo, input int hi, input string req, input string what);
        int bad = -1;
        for (int i = lo; i < hi; i++)
            if (bad < 0 && got_bits[i] !== exp_bits[i]) bad = i;
        check(bad < 0, req, what, (bad < 0) ? 0 : longint'(got_bits[bad]),
              (bad < 0) ? 0 : longint'(exp_bits[bad]));
    endtask

    // Sends one frame; at cycle 'disturb' (if >0) it pulses start and scrambles the inputs.
    task automatic run_frame(input logic [3:0] ty, input logic [7:0] ud, input logic lg,
                             input logic [127:0] pl, input logic [3:0] tg, input int disturb);
        logic prev_clk;
        int   cyc;
        int   plen;
        build(ty, ud, lg, pl, tg);
        plen = lg ? 128 : 16;
        @(negedge clk);
        frm_type = ty; user_data = ud; long_sel = lg; payload = pl; tag = tg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1 && tx_clk === 1'b0, "R2", "busy after start", busy, 1);
        prev_clk = 1'b0;
        got_len = 0;
        cyc = 0;
        while (cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (disturb > 0 && cyc == disturb) begin
                start = 1'b1;
                frm_type = ~ty; user_data = ~ud; long_sel = ~lg; payload = ~pl; tag = ~tg;
            end else begin
                start = 1'b0;
            end
            if (tx_clk !== prev_clk) begin
                if (got_len < 256) got_bits[got_len] = tx_dat;
                got_len++;
                prev_clk = tx_clk;
            end
            if (done === 1'b1) break;
        end
        check(got_len == exp_len, "R6", "edge count", got_len, exp_len);
        if (got_len == exp_len) begin
            check_span(0, 4, "R3", "leading pad");
            check_span(4, 8, "R4", "start delimiter");
            check_span(8, 20 + plen, "R5", "type/user/payload");
            check_span(20 + plen, 28 + plen, "R7", "crc");
            check_span(28 + plen, 32 + plen, "R5", "tag");
            check_span(32 + plen, 36 + plen, "R4", "end delimiter");
            check_span(36 + plen, 40 + plen, "R3", "trailing pad");
            if (disturb > 0)
                check_span(0, exp_len, "R9", "frame unchanged by input changes");
        end
        check(tx_clk === 1'b0, "R2", "clock low at end", tx_clk, 0);
        check(busy === 1'b0, "R10", "busy low with done", busy, 0);
        @(negedge clk);
        check(done === 1'b0, "R10", "done single cycle", done, 0);
        check(busy === 1'b0, "R8", "no restart after frame", busy, 0);
        check(tx_clk === 1'b0 && tx_dat === 1'b0, "R1", "idle between frames", {tx_clk, tx_dat}, 0);
    endtask

    task automatic test_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
        check(tx_clk === 1'b0 && tx_dat === 1'b0, "R1", "wire after reset", {tx_clk, tx_dat}, 0);
    endtask

    task automatic test_short;
        run_frame(4'b0100, 8'hA5, 1'b0, 128'h1234, 4'hC, 0);
    endtask

    task automatic test_short_ones;
        run_frame(4'hF, 8'hFF, 1'b0, {112'h5555, 16'hFFFF}, 4'hF, 0);
    endtask

    task automatic test_long;
        run_frame(4'h9, 8'h3C, 1'b1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 4'h6, 0);
    endtask

    task automatic test_long_disturb;
        run_frame(4'h2, 8'h81, 1'b1, 128'hDEAD_BEEF_0000_FFFF_1357_9BDF_2468_ACE0, 4'h9, 40);
    endtask

    task automatic test_short_disturb;
        run_frame(4'b0100, 8'h0F, 1'b0, 128'h8001, 4'h3, 12);
    endtask

    initial begin
        test_reset();
        test_short();
        test_short_ones();
        test_long();
        test_long_disturb();
        test_short_disturb();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule